// File: doc/BRIEF.md
# Operand Bypass and Load-Stall Controller

This block is the hazard-control logic of a five-stage in-order pipeline (fetch, decode/register read, execute, memory, write-back). Every instruction writes the register file in the fifth stage, including ALU operations, which pass through the memory stage doing nothing. As a result there is one write port and results are always ready at two fixed places: the execute/memory boundary and the memory/write-back boundary.

For the instruction now in execute, the block compares its two source indices with the destination indices of the two older instructions. It then picks, for each ALU operand, whether the value comes from the register file, the memory-stage result or the write-back-stage result. A load result only exists after the memory stage. A load in execute whose destination is read by the instruction in decode therefore cannot be bypassed. In that case the block holds the PC and the fetch/decode register, and it replaces the decode-to-execute transfer with a bubble for that cycle. After that single stall the normal bypass path covers the dependency, so steady-state throughput stays at one instruction per clock.

The block is purely combinational from its data inputs to its outputs. The clock is used only by the embedded property checks. The synchronous reset forces the outputs to their idle values.

Top module: `hzd_unit`

## Requirements
- R1: When the memory-stage producer has its write enable set, a non-zero destination, and a destination equal to operand A's source index (`ex_rs`), `fwd_a` is 2'b10.
- R2: When R1 does not apply and the write-back-stage producer has its write enable set, a non-zero destination, and a destination equal to `ex_rs`, `fwd_a` is 2'b01.
- R3: When both producers match the same source, the memory-stage (younger) result wins and the select is 2'b10.
- R4: When no producer matches, the select is 2'b00 (register file).
- R5: Register index 0 never produces a forward or a stall, whatever the write enables are.
- R6: A producer whose write enable is clear is never a match, for either forwarding or stalling.
- R7: When the instruction in execute is a load (`ex_is_load`=1) with write enable set and a non-zero destination equal to `id_rs` or `id_rt`, `hold_fetch` and `bubble_ex` are both 1 in that same cycle.
- R8: `hold_fetch` and `bubble_ex` are always equal, and neither is asserted when the instruction in execute is not a load. ALU producers are resolved only by bypassing.
- R9: Operand B (`fwd_b`, source `ex_rt`) follows R1 to R6 independently of operand A.
- R10: While `rst` is high, both selects are 2'b00 and both stall outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset, forces idle outputs |
| id_rs | input | 5 | First source index of the instruction in decode |
| id_rt | input | 5 | Second source index of the instruction in decode |
| ex_rs | input | 5 | Operand A source index of the instruction in execute |
| ex_rt | input | 5 | Operand B source index of the instruction in execute |
| ex_rd | input | 5 | Destination index of the instruction in execute |
| ex_wr_en | input | 1 | Register-write enable of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| mem_rd | input | 5 | Destination index in the memory stage |
| mem_wr_en | input | 1 | Register-write enable in the memory stage |
| wb_rd | input | 5 | Destination index in the write-back stage |
| wb_wr_en | input | 1 | Register-write enable in the write-back stage |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| hold_fetch | output | 1 | Hold PC and fetch/decode register |
| bubble_ex | output | 1 | Load a no-write bubble into execute |

## Verification
On every cycle, the embedded properties check the younger-wins priority, the exclusion of index 0, that clear write enables never select a bypass, that hold and bubble agree, and that no stall occurs without a load in execute. Only the bench sweeps show that each select takes exactly the expected code for every combination of indices and enables. The sweeps also show that a stall really fires on every load-use pair in either source slot, and that the reset state is idle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    parameter int IDX_W = 5;
    parameter int NUM_OPND = 2;

    typedef logic [IDX_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;

    typedef struct packed {
        reg_idx_t idx;
        logic     wr;
    } producer_t;

    // True when producer p will write register r (index 0 is never written)
    function automatic logic writes_to(producer_t p, reg_idx_t r);
        return p.wr && (p.idx != '0) && (p.idx == r);
    endfunction

endpackage

// File: rtl/hzd_fwd_mux.sv
module hzd_fwd_mux
    import hzd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_idx_t  src,
    input  producer_t mem_p,
    input  producer_t wb_p,
    output opnd_src_e sel
);

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = writes_to(mem_p, src);
        wb_hit  = writes_to(wb_p, src);
        if (rst)          sel = SRC_REGFILE;
        else if (mem_hit) sel = SRC_MEM;
        else if (wb_hit)  sel = SRC_WB;
        else              sel = SRC_REGFILE;
    end

    // R3: youngest producer wins
    a_r3_mem_priority: assert property (@(posedge clk) disable iff (rst)
        (mem_p.wr && mem_p.idx == src && src != '0) |-> sel == SRC_MEM);

    // R5: index 0 never bypassed
    a_r5_zero_no_fwd: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> sel == SRC_REGFILE);

    // R6: no enabled writer, no bypass
    a_r6_need_wr_en: assert property (@(posedge clk) disable iff (rst)
        (!mem_p.wr && !wb_p.wr) |-> sel == SRC_REGFILE);

endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
    import hzd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  producer_t ex_p,
    input  logic      ex_is_load,
    input  reg_idx_t  id_src [NUM_OPND],
    output logic      stall
);

    logic [NUM_OPND-1:0] dep;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_dep
        assign dep[g] = writes_to(ex_p, id_src[g]);
    end

    assign stall = !rst && ex_is_load && (|dep);

    // R8: ALU producers never stall
    a_r8_load_only: assert property (@(posedge clk) disable iff (rst)
        !ex_is_load |-> !stall);

    // R5: a load to index 0 never stalls
    a_r5_zero_no_stall: assert property (@(posedge clk) disable iff (rst)
        (ex_p.idx == '0) |-> !stall);

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] id_rs,
    input  logic [IDX_W-1:0] id_rt,
    input  logic [IDX_W-1:0] ex_rs,
    input  logic [IDX_W-1:0] ex_rt,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic             wb_wr_en,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             hold_fetch,
    output logic             bubble_ex
);

    producer_t ex_p, mem_p, wb_p;
    reg_idx_t  ex_src [NUM_OPND];
    reg_idx_t  id_src [NUM_OPND];
    opnd_src_e sel    [NUM_OPND];
    logic      stall;

    assign ex_p  = '{idx: ex_rd,  wr: ex_wr_en};
    assign mem_p = '{idx: mem_rd, wr: mem_wr_en};
    assign wb_p  = '{idx: wb_rd,  wr: wb_wr_en};

    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;
    assign id_src[0] = id_rs;
    assign id_src[1] = id_rt;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        hzd_fwd_mux u_mux (
            .clk   (clk),
            .rst   (rst),
            .src   (ex_src[g]),
            .mem_p (mem_p),
            .wb_p  (wb_p),
            .sel   (sel[g])
        );
    end

    hzd_load_use u_lu (
        .clk        (clk),
        .rst        (rst),
        .ex_p       (ex_p),
        .ex_is_load (ex_is_load),
        .id_src     (id_src),
        .stall      (stall)
    );

    assign fwd_a      = sel[0];
    assign fwd_b      = sel[1];
    assign hold_fetch = stall;
    assign bubble_ex  = stall;

    // R8: hold and bubble move together
    a_r8_hold_bubble_pair: assert property (@(posedge clk) disable iff (rst)
        hold_fetch == bubble_ex);

    // R7: a load-use pair on the first source must stall
    a_r7_stall_on_rs: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_wr_en && ex_rd != '0 && ex_rd == id_rs) |-> hold_fetch);

    // R10: idle outputs under reset
    always_comb begin
        if (rst) a_r10_reset_idle: assert (fwd_a == 2'b00 && fwd_b == 2'b00 && !bubble_ex);
    end

endmodule

// File: tb/tb_hzd_unit.sv
module tb_hzd_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic         ex_wr_en, ex_is_load, mem_wr_en, wb_wr_en;
    logic [1:0]   fwd_a, fwd_b;
    logic         hold_fetch, bubble_ex;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_unit dut (
        .clk(clk), .rst(rst),
        .id_rs(id_rs), .id_rt(id_rt),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
        .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
        .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .hold_fetch(hold_fetch), .bubble_ex(bubble_ex)
    );

    function automatic logic [1:0] exp_sel(logic [W-1:0] s, logic [W-1:0] md, logic mw,
                                           logic [W-1:0] wd, logic ww);
        if (mw && md != 0 && md == s) return 2'b10;
        if (ww && wd != 0 && wd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(logic [W-1:0] s, logic [W-1:0] md, logic mw,
                                      logic [W-1:0] wd, logic ww, bit opb);
        if (opb) return "R9";
        if (s == 0) return "R5";
        if (md == s && wd == s && mw && ww) return "R3";
        if ((md == s && !mw) || (wd == s && !ww)) return "R6";
        if (md == s && mw) return "R1";
        if (wd == s && ww) return "R2";
        return "R4";
    endfunction

    task automatic check(string tag, int act, int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        id_rs = 0; id_rt = 0; ex_rs = 0; ex_rt = 0; ex_rd = 0;
        ex_wr_en = 0; ex_is_load = 0; mem_rd = 0; mem_wr_en = 0;
        wb_rd = 0; wb_wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        // R10: reset idle even with a live load-use and bypass pattern
        @(posedge clk); #1;
        ex_rs = 3; ex_rt = 3; mem_rd = 3; mem_wr_en = 1;
        ex_rd = 3; ex_wr_en = 1; ex_is_load = 1; id_rs = 3;
        @(negedge clk);
        check("R10 fwd_a", fwd_a, 0);
        check("R10 fwd_b", fwd_b, 0);
        check("R10 hold", hold_fetch, 0);
        check("R10 bubble", bubble_ex, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        idle_inputs();

        // R1..R6, R9: sweep operand indices 0..3 (and 31) with all enable pairs
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 4; b++)
                for (int m = 0; m < 4; m++)
                    for (int w = 0; w < 4; w++)
                        for (int en = 0; en < 4; en++) begin
                            @(posedge clk); #1;
                            ex_rs = (a == 4) ? 31 : a[W-1:0];
                            ex_rt = b[W-1:0];
                            mem_rd = (a == 4 && m == 3) ? 31 : m[W-1:0];
                            wb_rd  = w[W-1:0];
                            mem_wr_en = en[1];
                            wb_wr_en  = en[0];
                            @(negedge clk);
                            check(sel_tag(ex_rs, mem_rd, mem_wr_en, wb_rd, wb_wr_en, 0), fwd_a,
                                  exp_sel(ex_rs, mem_rd, mem_wr_en, wb_rd, wb_wr_en));
                            check(sel_tag(ex_rt, mem_rd, mem_wr_en, wb_rd, wb_wr_en, 1), fwd_b,
                                  exp_sel(ex_rt, mem_rd, mem_wr_en, wb_rd, wb_wr_en));
                            check("R8 no stall without load", hold_fetch, 0);
                        end
        idle_inputs();

        // R7, R8, R5, R6: sweep load-use detection
        for (int r = 0; r < 4; r++)
            for (int t = 0; t < 4; t++)
                for (int d = 0; d < 4; d++)
                    for (int f = 0; f < 4; f++) begin
                        int exp_st;
                        @(posedge clk); #1;
                        id_rs = r[W-1:0]; id_rt = t[W-1:0]; ex_rd = d[W-1:0];
                        ex_is_load = f[1]; ex_wr_en = f[0];
                        @(negedge clk);
                        exp_st = (f[1] && f[0] && d != 0 && (d == r || d == t)) ? 1 : 0;
                        if (d == 0)       check("R5 stall", hold_fetch, exp_st);
                        else if (!f[0])   check("R6 stall", hold_fetch, exp_st);
                        else if (!f[1])   check("R8 stall", hold_fetch, exp_st);
                        else              check("R7 stall", hold_fetch, exp_st);
                        check("R8 bubble", bubble_ex, exp_st);
                    end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule